// File: doc/BRIEF.md
# Block-Skip Binary Adder

This is a combinational adder of parameterised width for the core of a phase accumulator in a direct digital synthesiser. The operand bits are split into consecutive blocks. Inside a block the carry ripples from bit to bit through full-adder cells, and each full-adder cell is built from two half adders. A block whose bits all propagate can also pass its incoming carry straight to the next block over a skip path. The adder has no registers. It produces the sum and the carry-out from the current operands and carry-in.

The block layout is chosen by one parameter, which selects one of three partitions:

- Equal blocks of a set size.
- A graded profile. Blocks at both ends start at one bit and grow by one bit per step toward the centre. Whatever width remains goes into a single central block.
- A custom list of block sizes, packed eight bits per entry with entry 0 at the least significant end.

Changing the partition changes only the carry timing. The arithmetic result is the same for all three. The accumulator register and its feedback path sit outside this block.

Top module: `csk_adder`

## Requirements
- R1: `{carry_out, sum}` equals `op_a + op_b + carry_in` taken to WIDTH+1 bits, for WIDTH of 8, 16, 32 and 64. The result holds in the same cycle the operands are applied, with no clock involved.
- R2: With `op_a` all ones, `op_b` equal to 1 and `carry_in` 0, the outputs are `sum` = 0 and `carry_out` = 1. This is the longest carry path: it starts at bit 0 and ends at the top bit.
- R3: With `op_a` all ones, `op_b` 0 and `carry_in` 1, every bit propagates. The carry-in then reaches `carry_out` = 1 and `sum` = 0. With both operands 0 and `carry_in` 1, `sum` = 1 and `carry_out` = 0.
- R4: A bit propagates when its two operand bits differ (their XOR is 1). A block in which every bit propagates sends its carry-in unchanged to the next block. So the operands 0x55..55 and 0xAA..AA give `sum` all ones with `carry_out` = 0 when `carry_in` is 0, and `sum` = 0 with `carry_out` = 1 when `carry_in` is 1.
- R5: A carry generated only in the most significant bit appears on `carry_out` and leaves `sum` at 0. This is checked with both operands equal to 1 << (WIDTH-1).
- R6: The equal-block configuration (CFG = CSK_FIXED, with FIX_BLK = 4) and the graded configuration (CFG = CSK_VARIABLE) give identical outputs for identical operands at every supported width.
- R7: The custom configuration (CFG = CSK_CUSTOM) uses CUST_NUM block sizes from CUST_SIZES. For example, sizes 3 then 5 make an 8-bit adder that still meets R1. Elaboration stops with an error in any of these cases:
  - the sizes do not add up to WIDTH;
  - any block has size 0;
  - the number of blocks exceeds 32;
  - the equal-block size does not divide WIDTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
A fault in a block's skip term or its ripple chain shows up at the ports at once, because nothing is registered. It appears as a wrong `carry_out` or a wrong run of upper `sum` bits on the same operands that exposed the fault. The all-ones and alternating-bit patterns force every block onto its skip path, and random operands cover the cases where carries are generated and stopped. Running both partitions side by side on the same operands means a fault that exists in only one layout still shows as a mismatch between the two.

// File: rtl/csk_pkg.sv
`timescale 1ns/1ps
package csk_pkg;

   localparam int unsigned MAX_BLK = 32;
   localparam int unsigned SZW     = 8;

   typedef enum logic [1:0] {
      CSK_CUSTOM   = 2'd0,
      CSK_FIXED    = 2'd1,
      CSK_VARIABLE = 2'd2
   } csk_cfg_e;

   typedef logic [MAX_BLK*SZW-1:0] size_vec_t;

   // number of size pairs (1,2,3..) that fit at both ends of a graded profile
   function automatic int unsigned var_pairs(input int unsigned w);
      int unsigned rem;
      int unsigned n;
      bit          done;
      rem  = w;
      n    = 0;
      done = 1'b0;
      for (int unsigned s = 1; s <= MAX_BLK / 2; s++) begin
         if (!done) begin
            if (rem > 2 * s) begin
               rem = rem - 2 * s;
               n   = s;
            end else begin
               done = 1'b1;
            end
         end
      end
      return n;
   endfunction

   function automatic int unsigned blk_num(input csk_cfg_e cfg, input int unsigned w,
                                           input int unsigned fix, input int unsigned cust_num);
      int unsigned r;
      case (cfg)
         CSK_FIXED:    r = (fix == 0) ? 0 : w / fix;
         CSK_VARIABLE: r = 2 * var_pairs(w) + 1;
         default:      r = cust_num;
      endcase
      return r;
   endfunction

   function automatic int unsigned blk_size(input csk_cfg_e cfg, input int unsigned w,
                                            input int unsigned fix, input size_vec_t cust,
                                            input int unsigned i);
      int unsigned n;
      int unsigned r;
      n = var_pairs(w);
      case (cfg)
         CSK_FIXED: r = fix;
         CSK_VARIABLE: begin
            if (i < n)       r = i + 1;
            else if (i == n) r = w - n * (n + 1);
            else             r = 2 * n + 1 - i;
         end
         default: r = (i < MAX_BLK) ? int'(cust[i*SZW +: SZW]) : 0;
      endcase
      return r;
   endfunction

   // bit position where block i starts
   function automatic int unsigned blk_lsb(input csk_cfg_e cfg, input int unsigned w,
                                           input int unsigned fix, input size_vec_t cust,
                                           input int unsigned i);
      int unsigned acc;
      acc = 0;
      for (int unsigned j = 0; j < MAX_BLK; j++) begin
         if (j < i) acc = acc + blk_size(cfg, w, fix, cust, j);
      end
      return acc;
   endfunction

   function automatic int unsigned blk_min(input csk_cfg_e cfg, input int unsigned w,
                                           input int unsigned fix, input size_vec_t cust,
                                           input int unsigned num);
      int unsigned m;
      m = 255;
      for (int unsigned j = 0; j < MAX_BLK; j++) begin
         if (j < num && blk_size(cfg, w, fix, cust, j) < m) m = blk_size(cfg, w, fix, cust, j);
      end
      return m;
   endfunction

endpackage

// File: rtl/csk_ha.sv
`timescale 1ns/1ps
module csk_ha (
   input  logic x,
   input  logic y,
   output logic sum,
   output logic cry
);
   assign sum = x ^ y;
   assign cry = x & y;
endmodule

// File: rtl/csk_fa.sv
`timescale 1ns/1ps
module csk_fa (
   input  logic a,
   input  logic b,
   input  logic ci,
   output logic s,
   output logic co,
   output logic p
);
   logic g_ab;
   logic g_pc;

   csk_ha u_h0 (.x(a), .y(b),  .sum(p), .cry(g_ab));
   csk_ha u_h1 (.x(p), .y(ci), .sum(s), .cry(g_pc));

   assign co = g_ab | g_pc;

   always_comb begin
      if (!$isunknown({a, b, ci})) begin
         p_fa_sum_r1: assert ({co, s} == (2'(a) + 2'(b) + 2'(ci)));
      end
   end
endmodule

// File: rtl/csk_block.sv
`timescale 1ns/1ps
module csk_block #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] s,
   output logic         cout,
   output logic         prop_all
);
   logic [W:0]   c;
   logic [W-1:0] p;

   assign c[0] = cin;

   for (genvar j = 0; j < W; j++) begin : g_bit
      csk_fa u_fa (
         .a  (a[j]),
         .b  (b[j]),
         .ci (c[j]),
         .s  (s[j]),
         .co (c[j+1]),
         .p  (p[j])
      );
   end

   assign prop_all = &p;

   if (W == 1) begin : g_noskip
      // a single cell already forwards cin when it propagates
      assign cout = c[W];
   end else begin : g_skip
      assign cout = c[W] | (prop_all & cin);
   end

   always_comb begin
      if (!$isunknown({a, b, cin})) begin
         p_skip_fwd_r4: assert (!prop_all || (cout == cin));
         p_blk_sum_r1:  assert ({cout, s} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}));
      end
   end
endmodule

// File: rtl/csk_adder.sv
`timescale 1ns/1ps
module csk_adder #(
   parameter int unsigned         WIDTH      = 32,
   parameter csk_pkg::csk_cfg_e   CFG        = csk_pkg::CSK_VARIABLE,
   parameter int unsigned         FIX_BLK    = 4,
   parameter int unsigned         CUST_NUM   = 1,
   parameter csk_pkg::size_vec_t  CUST_SIZES = csk_pkg::size_vec_t'(32)
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             carry_in,
   output logic [WIDTH-1:0] sum,
   output logic             carry_out
);
   localparam int unsigned NUM   = csk_pkg::blk_num(CFG, WIDTH, FIX_BLK, CUST_NUM);
   localparam int unsigned TOTAL = csk_pkg::blk_lsb(CFG, WIDTH, FIX_BLK, CUST_SIZES, NUM);
   localparam int unsigned MINSZ = csk_pkg::blk_min(CFG, WIDTH, FIX_BLK, CUST_SIZES, NUM);
   localparam bit FIX_BAD = (CFG == csk_pkg::CSK_FIXED) &&
                            ((FIX_BLK == 0) || ((WIDTH % ((FIX_BLK == 0) ? 1 : FIX_BLK)) != 0));

   if (WIDTH == 0) begin : g_err_w
      $error("csk_adder: WIDTH must be at least one");
   end else if (NUM == 0 || NUM > csk_pkg::MAX_BLK) begin : g_err_n
      $error("csk_adder: block count %0d out of range", NUM);
   end else if (FIX_BAD) begin : g_err_f
      $error("csk_adder: FIX_BLK %0d does not divide WIDTH %0d", FIX_BLK, WIDTH);
   end else if (TOTAL != WIDTH) begin : g_err_t
      $error("csk_adder: block sizes sum to %0d, WIDTH is %0d", TOTAL, WIDTH);
   end else if (MINSZ == 0) begin : g_err_z
      $error("csk_adder: a block has size zero");
   end else begin : g_core
      logic [NUM:0]   blk_c;
      logic [NUM-1:0] blk_p;

      assign blk_c[0] = carry_in;

      for (genvar i = 0; i < NUM; i++) begin : g_blk
         localparam int unsigned SZ  = csk_pkg::blk_size(CFG, WIDTH, FIX_BLK, CUST_SIZES, i);
         localparam int unsigned LSB = csk_pkg::blk_lsb(CFG, WIDTH, FIX_BLK, CUST_SIZES, i);
         csk_block #(.W(SZ)) u_blk (
            .a        (op_a[LSB +: SZ]),
            .b        (op_b[LSB +: SZ]),
            .cin      (blk_c[i]),
            .s        (sum[LSB +: SZ]),
            .cout     (blk_c[i+1]),
            .prop_all (blk_p[i])
         );
      end

      assign carry_out = blk_c[NUM];

      always_comb begin
         if (!$isunknown({op_a, op_b, carry_in})) begin
            p_total_r1: assert ({carry_out, sum} ==
                                ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}));
            p_chain_fwd_r3: assert (!(&blk_p) || (carry_out == carry_in));
            p_allones_r2: assert (!((&op_a) && (op_b == WIDTH'(1)) && !carry_in) ||
                                  (carry_out && (sum == '0)));
         end
      end
   end
endmodule

// File: tb/csk_adder_bench.sv
`timescale 1ns/1ps
module csk_adder_bench;

   typedef struct {
      logic [8:0]  e8;
      logic [16:0] e16;
      logic [32:0] e32;
      logic [64:0] e64;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [63:0] op_a = '0;
   logic [63:0] op_b = '0;
   logic        cin  = 1'b0;
   int          checks = 0;
   int          failures = 0;
   bit          done = 1'b0;
   item_t       q[$];

   always #2 clk = ~clk;

   logic [7:0]  s_v8,  s_f8,  s_c8;
   logic [15:0] s_v16, s_f16;
   logic [31:0] s_v32, s_f32;
   logic [63:0] s_v64, s_f64;
   logic c_v8, c_f8, c_c8, c_v16, c_f16, c_v32, c_f32, c_v64, c_f64;

   csk_adder u_csk_adder (.op_a(op_a[31:0]), .op_b(op_b[31:0]), .carry_in(cin),
                          .sum(s_v32), .carry_out(c_v32));
   csk_adder #(.WIDTH(32), .CFG(csk_pkg::CSK_FIXED), .FIX_BLK(4)) u_csk_adder_f32 (
      .op_a(op_a[31:0]), .op_b(op_b[31:0]), .carry_in(cin), .sum(s_f32), .carry_out(c_f32));
   csk_adder #(.WIDTH(8), .CFG(csk_pkg::CSK_VARIABLE)) u_csk_adder_v8 (
      .op_a(op_a[7:0]), .op_b(op_b[7:0]), .carry_in(cin), .sum(s_v8), .carry_out(c_v8));
   csk_adder #(.WIDTH(8), .CFG(csk_pkg::CSK_FIXED), .FIX_BLK(4)) u_csk_adder_f8 (
      .op_a(op_a[7:0]), .op_b(op_b[7:0]), .carry_in(cin), .sum(s_f8), .carry_out(c_f8));
   csk_adder #(.WIDTH(16), .CFG(csk_pkg::CSK_VARIABLE)) u_csk_adder_v16 (
      .op_a(op_a[15:0]), .op_b(op_b[15:0]), .carry_in(cin), .sum(s_v16), .carry_out(c_v16));
   csk_adder #(.WIDTH(16), .CFG(csk_pkg::CSK_FIXED), .FIX_BLK(4)) u_csk_adder_f16 (
      .op_a(op_a[15:0]), .op_b(op_b[15:0]), .carry_in(cin), .sum(s_f16), .carry_out(c_f16));
   csk_adder #(.WIDTH(64), .CFG(csk_pkg::CSK_VARIABLE)) u_csk_adder_v64 (
      .op_a(op_a), .op_b(op_b), .carry_in(cin), .sum(s_v64), .carry_out(c_v64));
   csk_adder #(.WIDTH(64), .CFG(csk_pkg::CSK_FIXED), .FIX_BLK(4)) u_csk_adder_f64 (
      .op_a(op_a), .op_b(op_b), .carry_in(cin), .sum(s_f64), .carry_out(c_f64));
   // R7: custom partition, 3 bits then 5 bits
   csk_adder #(.WIDTH(8), .CFG(csk_pkg::CSK_CUSTOM), .CUST_NUM(2),
               .CUST_SIZES(csk_pkg::size_vec_t'(16'h0503))) u_csk_adder_c8 (
      .op_a(op_a[7:0]), .op_b(op_b[7:0]), .carry_in(cin), .sum(s_c8), .carry_out(c_c8));

   task automatic chk(input string tag, input string who, input logic [64:0] act,
                      input logic [64:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s act=%h exp=%h", tag, who, act, exp);
      end
   endtask

   task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic ci,
                        input string tag);
      item_t it;
      @(posedge clk);
      op_a = a;
      op_b = b;
      cin  = ci;
      it.e8  = {1'b0, a[7:0]}  + {1'b0, b[7:0]}  + {8'b0, ci};
      it.e16 = {1'b0, a[15:0]} + {1'b0, b[15:0]} + {16'b0, ci};
      it.e32 = {1'b0, a[31:0]} + {1'b0, b[31:0]} + {32'b0, ci};
      it.e64 = {1'b0, a}       + {1'b0, b}       + {64'b0, ci};
      it.tag = tag;
      q.push_back(it);
   endtask

   always @(negedge clk) begin : monitor
      item_t it;
      if (q.size() != 0) begin
         it = q.pop_front();
         chk(it.tag, "v8",  65'({c_v8,  s_v8}),  65'(it.e8));
         chk(it.tag, "f8",  65'({c_f8,  s_f8}),  65'(it.e8));
         chk(it.tag, "v16", 65'({c_v16, s_v16}), 65'(it.e16));
         chk(it.tag, "f16", 65'({c_f16, s_f16}), 65'(it.e16));
         chk(it.tag, "v32", 65'({c_v32, s_v32}), 65'(it.e32));
         chk(it.tag, "f32", 65'({c_f32, s_f32}), 65'(it.e32));
         chk(it.tag, "v64", {c_v64, s_v64}, it.e64);
         chk(it.tag, "f64", {c_f64, s_f64}, it.e64);
         chk("R7 custom 3+5", "c8", 65'({c_c8, s_c8}), 65'(it.e8));
         // R6: the two partitions agree
         chk("R6 fixed vs graded", "w8",  65'({c_f8,  s_f8}),  65'({c_v8,  s_v8}));
         chk("R6 fixed vs graded", "w16", 65'({c_f16, s_f16}), 65'({c_v16, s_v16}));
         chk("R6 fixed vs graded", "w32", 65'({c_f32, s_f32}), 65'({c_v32, s_v32}));
         chk("R6 fixed vs graded", "w64", {c_f64, s_f64}, {c_v64, s_v64});
      end
   end

   task automatic summary;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      #400000;
      if (!done) begin
         failures++;
         $display("FAIL R1 watchdog act=hung exp=finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: zero operands during reset give zero outputs
      chk("R1 reset", "v64", {c_v64, s_v64}, 65'd0);
      chk("R1 reset", "f8",  65'({c_f8, s_f8}), 65'd0);
      rst = 1'b0;

      drive('1, 64'd1, 1'b0, "R2 all ones plus one");
      drive('1, 64'd0, 1'b1, "R3 carry-in through every block");
      drive(64'd0, 64'd0, 1'b1, "R3 carry-in alone");
      drive({32{2'b01}}, {32{2'b10}}, 1'b0, "R4 all propagate cin0");
      drive({32{2'b01}}, {32{2'b10}}, 1'b1, "R4 all propagate cin1");
      drive({32{2'b01}} & ~64'h10, {32{2'b10}}, 1'b1, "R4 one killed bit");
      drive(64'h80, 64'h80, 1'b0, "R5 top-bit carry w8");
      drive(64'h8000, 64'h8000, 1'b0, "R5 top-bit carry w16");
      drive(64'h8000_0000, 64'h8000_0000, 1'b0, "R5 top-bit carry w32");
      drive(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, "R5 top-bit carry w64");
      drive(64'd0, 64'd0, 1'b0, "R1 zeros");
      drive('1, '1, 1'b1, "R1 all ones both");
      drive(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 1'b1, "R1 mixed");
      for (int n = 0; n < 300; n++) begin
         drive({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R1 random");
      end

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule